// File: doc/BRIEF.md
# Second-Aligned Sampler with Frame Tagging

This block paces waveform acquisition from a once-per-second timing pulse. After reset it stays quiet until the first rising edge of the pulse pin. From then on it emits ADC sample strobes at a fixed rate. The strobe divider is rebuilt from the system clock frequency and restarted on every pulse edge, so the first sample of every second falls on the second boundary. The samples of one second are split into a fixed number of equal frames.

Each sample the ADC returns goes into a synchronous FIFO together with its tag: the UTC second latched at the pulse edge, the frame index inside that second, and first/last-of-frame markers. A downstream consumer drains the FIFO frame by frame through a show-ahead read port. Overflow and underflow are kept as sticky flags. A missing pulse raises a loss flag and stops acquisition until the pulse returns. A pulse that arrives while the time value is not valid also yields no samples for that second.

Top module: `ppsFrameSampler`

## Requirements
- R1: After reset and before the first detected pulse edge, `adcStrobe` stays low and nothing is written to the FIFO.
- R2: A pulse edge on `ppsIn` is seen two clock edges after the pin rises (two-flop synchronizer). On the next edge the divider and frame counters restart, so `adcStrobe` is high in the cycle right after detection and that sample is tagged frame 0, first of frame.
- R3: Within a second, consecutive strobes are exactly CLK_HZ/SAMPLE_HZ cycles apart.
- R4: At most SAMPLE_HZ strobes are issued per second. Once that count is reached, strobes stop until the next pulse edge.
- R5: Sample k of a second (k from 0) is tagged frame k/(SAMPLE_HZ/FRAMES). It carries `rdFirst`=1 when k mod SPF is 0 and `rdLast`=1 when k mod SPF is SPF-1.
- R6: Every entry is tagged with the `utcSec` value present at the pulse edge. If `timeValid` is low at that edge, no strobes are issued for that second.
- R7: If no pulse edge arrives within CLK_HZ*11/10 cycles of the previous one, `ppsLost` rises and strobes stop. The next edge clears `ppsLost`.
- R8: The FIFO returns entries in write order. The read port shows the head entry while `fifoEmpty` is low, and `rdEn` pops it. `fifoFull` and `fifoEmpty` are never both high.
- R9: A sample that arrives while the FIFO is full is dropped and sets the sticky `ovfFlag`. Only reset or `clrFlags` clears it.
- R10: `rdEn` while the FIFO is empty pops nothing and sets the sticky `udfFlag`. Only reset or `clrFlags` clears it.
- R11: `adcValid` with no strobe outstanding is ignored and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ppsIn | input | 1 | Once-per-second timing pulse, asynchronous |
| adcData | input | DATA_W | Converted sample word |
| adcValid | input | 1 | Sample word valid |
| utcSec | input | SEC_W | Current UTC second |
| timeValid | input | 1 | `utcSec` is trustworthy |
| clrFlags | input | 1 | Clears overflow and underflow flags |
| rdEn | input | 1 | Pop head entry |
| adcStrobe | output | 1 | Start-of-conversion strobe |
| rdSample | output | DATA_W | Head entry sample |
| rdSec | output | SEC_W | Head entry UTC second |
| rdFrame | output | FRAME_W | Head entry frame index |
| rdFirst | output | 1 | Head entry opens a frame |
| rdLast | output | 1 | Head entry closes a frame |
| fifoFull | output | 1 | FIFO full |
| fifoEmpty | output | 1 | FIFO empty |
| ovfFlag | output | 1 | Sticky overflow |
| udfFlag | output | 1 | Sticky underflow |
| ppsLost | output | 1 | Pulse missing for too long |

## Verification
The bench builds the block with CLK_HZ=200, SAMPLE_HZ=20, FRAMES=4 and an 8-entry FIFO. That gives one strobe every 10 cycles, 5 samples per frame and a loss timeout of 220 cycles. Full seconds, a short second, an untimed second and a lost pulse then take a few hundred cycles each. The small FIFO lets a single undrained second overflow it, which shows which samples are kept and which are dropped.

// File: rtl/ppsSamplerPkg.sv
package ppsSamplerPkg;
  typedef struct packed {
    logic push;
    logic first;
    logic last;
  } ctlStrobe_t;
endpackage

// File: rtl/ppsEdgeDet.sv
module ppsEdgeDet #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseOut
);
  logic [STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[STAGES-1:0], pinIn};
  end

  assign riseOut = syncQ[STAGES-1] & ~syncQ[STAGES];
endmodule

// File: rtl/sampleCtrl.sv
module sampleCtrl
  import ppsSamplerPkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SAMPLE_HZ = 50_000,
  parameter int FRAMES    = 10,
  parameter int SEC_W     = 32,
  parameter int FRAME_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ppsEdge,
  input  logic               adcValid,
  input  logic [SEC_W-1:0]   utcSec,
  input  logic               timeValid,
  output logic               adcStrobe,
  output logic               ppsLost,
  output ctlStrobe_t         strb,
  output logic [SEC_W-1:0]   tagSec,
  output logic [FRAME_W-1:0] tagFrame
);
  localparam int DIV      = CLK_HZ / SAMPLE_HZ;
  localparam int SPF      = SAMPLE_HZ / FRAMES;
  localparam int LOST_LIM = CLK_HZ + CLK_HZ / 10;
  localparam int DIV_W    = $clog2(DIV + 1);
  localparam int SPF_W    = $clog2(SPF + 1);
  localparam int LOST_W   = $clog2(LOST_LIM + 1);

  logic               running, seenPps, secDone, pend;
  logic               pendFirst, pendLast;
  logic [DIV_W-1:0]   divCnt;
  logic [SPF_W-1:0]   inFrame;
  logic [FRAME_W-1:0] frameIdx, pendFrame;
  logic [LOST_W-1:0]  lostCnt;
  logic [SEC_W-1:0]   secReg;

  assign adcStrobe = running && !secDone && (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0; seenPps <= 1'b0; secDone <= 1'b0; pend <= 1'b0;
      pendFirst <= 1'b0; pendLast <= 1'b0; pendFrame <= '0;
      divCnt <= '0; inFrame <= '0; frameIdx <= '0; lostCnt <= '0;
      secReg <= '0; ppsLost <= 1'b0;
    end else if (ppsEdge) begin
      running  <= timeValid;
      seenPps  <= 1'b1;
      ppsLost  <= 1'b0;
      lostCnt  <= '0;
      divCnt   <= '0;
      inFrame  <= '0;
      frameIdx <= '0;
      secDone  <= 1'b0;
      pend     <= 1'b0;
      secReg   <= utcSec;
    end else begin
      if (running && !secDone)
        divCnt <= (divCnt == DIV_W'(DIV - 1)) ? '0 : divCnt + 1'b1;

      if (adcStrobe) begin
        pend      <= 1'b1;
        pendFrame <= frameIdx;
        pendFirst <= (inFrame == '0);
        pendLast  <= (inFrame == SPF_W'(SPF - 1));
        if (inFrame == SPF_W'(SPF - 1)) begin
          inFrame <= '0;
          if (frameIdx == FRAME_W'(FRAMES - 1)) secDone <= 1'b1;
          else                                  frameIdx <= frameIdx + 1'b1;
        end else begin
          inFrame <= inFrame + 1'b1;
        end
      end else if (pend && adcValid) begin
        pend <= 1'b0;
      end

      if (seenPps && !ppsLost) begin
        if (lostCnt == LOST_W'(LOST_LIM - 1)) begin
          ppsLost <= 1'b1;
          running <= 1'b0;
          pend    <= 1'b0;
        end else begin
          lostCnt <= lostCnt + 1'b1;
        end
      end
    end
  end

  assign strb.push  = pend && adcValid;
  assign strb.first = pendFirst;
  assign strb.last  = pendLast;
  assign tagSec     = secReg;
  assign tagFrame   = pendFrame;
endmodule

// File: rtl/sampleFifo.sv
module sampleFifo
  import ppsSamplerPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SEC_W   = 32,
  parameter int FRAME_W = 4,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrSample,
  input  logic [SEC_W-1:0]   wrSec,
  input  logic [FRAME_W-1:0] wrFrame,
  input  logic               rdEn,
  input  logic               clrFlags,
  output logic [DATA_W-1:0]  rdSample,
  output logic [SEC_W-1:0]   rdSec,
  output logic [FRAME_W-1:0] rdFrame,
  output logic               rdFirst,
  output logic               rdLast,
  output logic               full,
  output logic               empty,
  output logic               ovfFlag,
  output logic               udfFlag
);
  localparam int AW    = $clog2(DEPTH);
  localparam int ENT_W = DATA_W + SEC_W + FRAME_W + 2;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr;
  logic             wrOk, rdOk;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign wrOk  = strb.push && !full;
  assign rdOk  = rdEn && !empty;

  always_ff @(posedge clk) begin
    if (wrOk)
      mem[wrPtr[AW-1:0]] <= {strb.first, strb.last, wrFrame, wrSec, wrSample};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; ovfFlag <= 1'b0; udfFlag <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (rdOk) rdPtr <= rdPtr + 1'b1;
      if (clrFlags) begin
        ovfFlag <= 1'b0;
        udfFlag <= 1'b0;
      end else begin
        if (strb.push && full) ovfFlag <= 1'b1;
        if (rdEn && empty)     udfFlag <= 1'b1;
      end
    end
  end

  assign {rdFirst, rdLast, rdFrame, rdSec, rdSample} = mem[rdPtr[AW-1:0]];
endmodule

// File: rtl/ppsFrameSampler.sv
module ppsFrameSampler
  import ppsSamplerPkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SAMPLE_HZ  = 50_000,
  parameter int FRAMES     = 10,
  parameter int DATA_W     = 16,
  parameter int SEC_W      = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int FRAME_W   = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ppsIn,
  input  logic [DATA_W-1:0]  adcData,
  input  logic               adcValid,
  input  logic [SEC_W-1:0]   utcSec,
  input  logic               timeValid,
  input  logic               clrFlags,
  input  logic               rdEn,
  output logic               adcStrobe,
  output logic [DATA_W-1:0]  rdSample,
  output logic [SEC_W-1:0]   rdSec,
  output logic [FRAME_W-1:0] rdFrame,
  output logic               rdFirst,
  output logic               rdLast,
  output logic               fifoFull,
  output logic               fifoEmpty,
  output logic               ovfFlag,
  output logic               udfFlag,
  output logic               ppsLost
);
  logic               ppsEdge;
  ctlStrobe_t         strb;
  logic [SEC_W-1:0]   tagSec;
  logic [FRAME_W-1:0] tagFrame;

  ppsEdgeDet #(.STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .pinIn(ppsIn), .riseOut(ppsEdge)
  );

  sampleCtrl #(
    .CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .FRAMES(FRAMES),
    .SEC_W(SEC_W), .FRAME_W(FRAME_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ppsEdge(ppsEdge), .adcValid(adcValid),
    .utcSec(utcSec), .timeValid(timeValid), .adcStrobe(adcStrobe),
    .ppsLost(ppsLost), .strb(strb), .tagSec(tagSec), .tagFrame(tagFrame)
  );

  sampleFifo #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .FRAME_W(FRAME_W), .DEPTH(FIFO_DEPTH)
  ) uFifo (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSample(adcData),
    .wrSec(tagSec), .wrFrame(tagFrame), .rdEn(rdEn), .clrFlags(clrFlags),
    .rdSample(rdSample), .rdSec(rdSec), .rdFrame(rdFrame),
    .rdFirst(rdFirst), .rdLast(rdLast), .full(fifoFull), .empty(fifoEmpty),
    .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );
endmodule

// File: rtl/ppsFrameSamplerChk.sv
module ppsFrameSamplerChk (
  input logic clk,
  input logic rstN,
  input logic ppsEdge,
  input logic timeValid,
  input logic pushReq,
  input logic adcStrobe,
  input logic ppsLost,
  input logic fifoFull,
  input logic fifoEmpty,
  input logic ovfFlag,
  input logic udfFlag,
  input logic rdEn,
  input logic clrFlags
);
  // R2
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ppsEdge |=> (adcStrobe == $past(timeValid)));

  // R3
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStrobe |=> !adcStrobe);

  // R7
  lost_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ppsLost |-> !adcStrobe);

  // R8
  full_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && fifoFull && !clrFlags) |=> ovfFlag);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrFlags) |=> ovfFlag);

  // R10
  udf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fifoEmpty && !clrFlags) |=> (udfFlag && fifoEmpty));
endmodule

bind ppsFrameSampler ppsFrameSamplerChk uChk (
  .clk(clk), .rstN(rstN), .ppsEdge(ppsEdge), .timeValid(timeValid),
  .pushReq(strb.push), .adcStrobe(adcStrobe), .ppsLost(ppsLost),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .ovfFlag(ovfFlag),
  .udfFlag(udfFlag), .rdEn(rdEn), .clrFlags(clrFlags)
);

// File: tb/tb_ppsFrameSampler.sv
module tb_ppsFrameSampler;
  localparam int CLK_HZ = 200, SAMPLE_HZ = 20, FRAMES = 4, DEPTH = 8;
  localparam int DIV = CLK_HZ / SAMPLE_HZ, SPF = SAMPLE_HZ / FRAMES;
  localparam int FRAME_W = 2;

  typedef struct packed {
    int unsigned sec;
    bit          tv;
    int unsigned gap;
    int unsigned expN;
    bit          expLost;
  } row_t;

  localparam row_t ROWS [5] = '{
    '{sec: 100, tv: 1'b1, gap: 200, expN: 20, expLost: 1'b0},
    '{sec: 101, tv: 1'b1, gap: 190, expN: 19, expLost: 1'b0},
    '{sec: 102, tv: 1'b0, gap: 200, expN: 0,  expLost: 1'b0},
    '{sec: 103, tv: 1'b1, gap: 300, expN: 20, expLost: 1'b1},
    '{sec: 104, tv: 1'b1, gap: 200, expN: 20, expLost: 1'b0}
  };

  logic clk = 0, rstN = 0, ppsIn = 0, adcValid = 0, timeValid = 0;
  logic clrFlags = 0, rdEn = 0;
  logic [15:0] adcData = '0;
  logic [31:0] utcSec = '0;
  logic adcStrobe, rdFirst, rdLast, fifoFull, fifoEmpty, ovfFlag, udfFlag, ppsLost;
  logic [15:0] rdSample;
  logic [31:0] rdSec;
  logic [FRAME_W-1:0] rdFrame;

  int checks = 0, fails = 0;
  int cyc = 0, prevStrobe = -1, rowStrobes = 0, gapBad = 0;
  int popped = 0, popBad = 0, adcSeq = 0;
  logic [31:0] curSec = '0;
  bit readerOn = 0, forceRd = 0, injectValid = 0, pendB = 0;

  ppsFrameSampler #(
    .CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .FRAMES(FRAMES),
    .DATA_W(16), .SEC_W(32), .FIFO_DEPTH(DEPTH)
  ) dut (
    .clk(clk), .rstN(rstN), .ppsIn(ppsIn), .adcData(adcData),
    .adcValid(adcValid), .utcSec(utcSec), .timeValid(timeValid),
    .clrFlags(clrFlags), .rdEn(rdEn), .adcStrobe(adcStrobe),
    .rdSample(rdSample), .rdSec(rdSec), .rdFrame(rdFrame),
    .rdFirst(rdFirst), .rdLast(rdLast), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .ovfFlag(ovfFlag), .udfFlag(udfFlag),
    .ppsLost(ppsLost)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ADC model, strobe monitor and reader, all at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    adcValid = pendB | injectValid;
    if (pendB) begin adcData = 16'(adcSeq); adcSeq++; end
    pendB = adcStrobe;
    if (adcStrobe) begin
      if (prevStrobe >= 0 && cyc - prevStrobe != DIV) gapBad++;
      prevStrobe = cyc;
      rowStrobes++;
    end
    rdEn = (readerOn && !fifoEmpty) || forceRd;
    if (readerOn && !fifoEmpty) begin
      // R5 R6 R8: tags and order per popped entry
      if (rdSample != 16'(popped) || rdSec != curSec ||
          int'(rdFrame) != popped / SPF || rdFirst != (popped % SPF == 0) ||
          rdLast != (popped % SPF == SPF - 1)) begin
        popBad++;
        $display("FAIL R5/R6: entry %0d actual data %0d sec %0d frame %0d f%0b l%0b expected frame %0d sec %0d",
                 popped, rdSample, rdSec, rdFrame, rdFirst, rdLast, popped / SPF, curSec);
      end
      popped++;
    end
  end

  task automatic pulsePps(input int unsigned sec, input bit tv);
    utcSec = sec; timeValid = tv; curSec = sec;
    popped = 0; adcSeq = 0; rowStrobes = 0; prevStrobe = -1; gapBad = 0; popBad = 0;
    ppsIn = 1; waitCyc(3); ppsIn = 0;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(5);
    rstN = 1;
    // R1: reset state and quiet before the first pulse
    waitCyc(40);
    check(fifoEmpty && !fifoFull && !ovfFlag && !udfFlag && !ppsLost, "R1 reset state",
          {fifoEmpty, fifoFull, ovfFlag, udfFlag, ppsLost}, 5'b10000);
    check(rowStrobes == 0, "R1 no strobe before pulse", rowStrobes, 0);
    // R11: stray valid ignored
    injectValid = 1; waitCyc(3); injectValid = 0; waitCyc(2);
    check(fifoEmpty == 1'b1, "R11 stray valid ignored", fifoEmpty, 1);

    readerOn = 1;
    for (int r = 0; r < 5; r++) begin
      pulsePps(ROWS[r].sec, ROWS[r].tv);
      // R2: strobe in the cycle after detection (pin + 2 edges + 1)
      if (r == 0) begin
        check(adcStrobe == 1'b1, "R2 first strobe aligned", adcStrobe, 1);
      end
      waitCyc(int'(ROWS[r].gap) - 3);
      // R4 R6: strobes per second
      check(rowStrobes == int'(ROWS[r].expN), "R4/R6 strobe count", rowStrobes, ROWS[r].expN);
      check(popped == int'(ROWS[r].expN) && popBad == 0, "R5/R8 entries popped", popped, ROWS[r].expN);
      // R3
      check(gapBad == 0, "R3 strobe spacing", gapBad, 0);
      // R7
      check(ppsLost == ROWS[r].expLost, "R7 pulse loss flag", ppsLost, ROWS[r].expLost);
    end

    // R9: overflow with no reader
    readerOn = 0;
    pulsePps(200, 1'b1);
    waitCyc(200);
    check(fifoFull && ovfFlag, "R9 overflow flagged", {fifoFull, ovfFlag}, 2'b11);
    readerOn = 1;
    waitCyc(20);
    check(popped == DEPTH && popBad == 0, "R9 oldest kept, rest dropped", popped, DEPTH);
    check(ovfFlag == 1'b1, "R9 flag sticky", ovfFlag, 1);
    clrFlags = 1; waitCyc(1); clrFlags = 0; waitCyc(1);
    check(ovfFlag == 1'b0, "R9 cleared", ovfFlag, 0);

    // R10: underflow
    readerOn = 0;
    forceRd = 1; waitCyc(1); forceRd = 0; waitCyc(1);
    check(udfFlag && fifoEmpty, "R10 underflow flagged", {udfFlag, fifoEmpty}, 2'b11);
    clrFlags = 1; waitCyc(1); clrFlags = 0; waitCyc(1);
    check(udfFlag == 1'b0, "R10 cleared", udfFlag, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule